// File: doc/BRIEF.md
# Watchdog External Reset Pulse Generator

This block sits beside a watchdog counter and turns its expiry strobe into a pulse on an external reset pin. The pulse length is held in a configuration register in microsecond units, offset by one. The active level (high or low) and the drive style (push-pull or open-drain) are also held there. The block counts the pulse on a 1 MHz tick that it receives as an input. It drives a pad value and a pad output enable, so an open-drain pin can be modelled by tri-stating the enable.

The configuration register has a guarded write rule. Every write updates the pulse-length field from the low bits. The polarity bit and the drive-mode bit change only when the top byte of the write carries one of four key values. Any other top byte leaves both bits as they were. A parameter selects an 8-bit or a 20-bit length field. Software can read the register back at any time.

Top module: `rstw_pulse_gen`

## Requirements
- R1: After reset the register reads 0x000000FF: width 0xFF, polarity active low, drive open-drain. The pad is idle with `pad_oe` low.
- R2: On read, bit 31 is the polarity (1 = active high) and bit 30 is the drive mode (1 = push-pull, 0 = open-drain). The width is in bits [PW-1:0], and every other bit reads 0.
- R3: A write whose top byte is 0xA5 sets active high; top byte 0x5A sets active low.
- R4: A write whose top byte is 0xA8 selects push-pull; top byte 0x8A selects open-drain.
- R5: A write with any other top byte leaves the polarity and drive bits unchanged. Every write, keyed or not, loads the width field from the low data bits.
- R6: With `WIDE_PW` = 1 the width field is 20 bits; with 0 it is 8 bits. Write bits above the field are discarded.
- R7: A stored width N gives a pulse that stays asserted for exactly N+1 `tick_us` strobes. N = 0 gives one tick.
- R8: An expiry strobe while `ext_en` is low produces no pulse.
- R9: An expiry during a running pulse reloads the count, so the pulse lasts N+1 ticks counted from that expiry.
- R10: In open-drain mode `pad_oe` is high only while the pulse runs, and `pad_out` equals the active level. In push-pull mode `pad_oe` is always high, and `pad_out` is the active level during the pulse and its inverse otherwise.
- R11: The pulse is asserted in the clock cycle after the expiry strobe is sampled with `ext_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data; top byte is the key |
| rd_data | output | 32 | Register read value |
| expire | input | 1 | Watchdog expiry strobe, one cycle |
| tick_us | input | 1 | 1 MHz time-base strobe, one cycle |
| ext_en | input | 1 | External pulse enable from the watchdog control |
| pad_out | output | 1 | Value driven toward the reset pad |
| pad_oe | output | 1 | Output enable for the reset pad |

## Verification
A corrupted polarity or drive bit shows on `rd_data` on the cycle after the write. When idle, push-pull mode drives the inactive level with the enable high, so a wrong bit also shows at the pad as an inverted or floating level. A wrong count in the pulse timer only shows when the pulse ends: the pulse stops one or more ticks early or late, so the bench counts ticks until release. A missed reload on retrigger also shows at that release, as a pulse that stops too soon after the second expiry.

// File: rtl/rstw_pkg.sv
package rstw_pkg;

    typedef enum logic {
        POL_LOW  = 1'b0,
        POL_HIGH = 1'b1
    } pol_e;

    typedef enum logic {
        DRV_OPEN = 1'b0,
        DRV_PUSH = 1'b1
    } drv_e;

    localparam logic [7:0] KEY_ACT_HIGH = 8'hA5;
    localparam logic [7:0] KEY_ACT_LOW  = 8'h5A;
    localparam logic [7:0] KEY_PUSH     = 8'hA8;
    localparam logic [7:0] KEY_OPEN     = 8'h8A;

    localparam int RD_POL_BIT = 31;
    localparam int RD_DRV_BIT = 30;

    function automatic int field_bits(input bit wide);
        return wide ? 20 : 8;
    endfunction

endpackage

// File: rtl/rstw_cfg_reg.sv
module rstw_cfg_reg
    import rstw_pkg::*;
#(
    parameter int PW_BITS = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_key,
    input  logic [PW_BITS-1:0] wr_width,
    output pol_e               pol,
    output drv_e               drv,
    output logic [PW_BITS-1:0] width
);

    localparam logic [PW_BITS-1:0] WIDTH_RST = PW_BITS'(8'hFF);

    typedef struct packed {
        pol_e               pol;
        drv_e               drv;
        logic [PW_BITS-1:0] width;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d.width = wr_width;
            case (wr_key)
                KEY_ACT_HIGH: cfg_d.pol = POL_HIGH;
                KEY_ACT_LOW:  cfg_d.pol = POL_LOW;
                KEY_PUSH:     cfg_d.drv = DRV_PUSH;
                KEY_OPEN:     cfg_d.drv = DRV_OPEN;
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.pol   <= POL_LOW;
            cfg_q.drv   <= DRV_OPEN;
            cfg_q.width <= WIDTH_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign pol   = cfg_q.pol;
    assign drv   = cfg_q.drv;
    assign width = cfg_q.width;

endmodule

// File: rtl/rstw_timer.sv
module rstw_timer #(
    parameter int PW_BITS = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  logic               tick,
    input  logic [PW_BITS-1:0] load_val,
    output logic               on
);

    typedef struct packed {
        logic               on;
        logic [PW_BITS-1:0] rem;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (fire) begin
            tmr_d.on  = 1'b1;
            tmr_d.rem = load_val;
        end else if (tmr_q.on && tick) begin
            if (tmr_q.rem == '0) begin
                tmr_d.on = 1'b0;
            end else begin
                tmr_d.rem = tmr_q.rem - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign on = tmr_q.on;

endmodule

// File: rtl/rstw_pad_drv.sv
module rstw_pad_drv
    import rstw_pkg::*;
(
    input  logic on,
    input  pol_e pol,
    input  drv_e drv,
    output logic pad_out,
    output logic pad_oe
);

    logic act_lvl;

    always_comb begin
        act_lvl = (pol == POL_HIGH);
        if (drv == DRV_PUSH) begin
            pad_oe  = 1'b1;
            pad_out = on ? act_lvl : ~act_lvl;
        end else begin
            pad_oe  = on;
            pad_out = act_lvl;
        end
    end

endmodule

// File: rtl/rstw_pulse_gen.sv
module rstw_pulse_gen
    import rstw_pkg::*;
#(
    parameter bit WIDE_PW = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic        expire,
    input  logic        tick_us,
    input  logic        ext_en,
    output logic        pad_out,
    output logic        pad_oe
);

    localparam int PW_BITS  = field_bits(WIDE_PW);
    localparam int GAP_BITS = RD_DRV_BIT - PW_BITS;

    pol_e               pol;
    drv_e               drv;
    logic [PW_BITS-1:0] width;
    logic               pulse_on;
    logic               fire;

    assign fire = expire && ext_en;

    rstw_cfg_reg #(.PW_BITS(PW_BITS)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_key   (wr_data[31:24]),
        .wr_width (wr_data[PW_BITS-1:0]),
        .pol      (pol),
        .drv      (drv),
        .width    (width)
    );

    rstw_timer #(.PW_BITS(PW_BITS)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .tick     (tick_us),
        .load_val (width),
        .on       (pulse_on)
    );

    rstw_pad_drv u_pad (
        .on      (pulse_on),
        .pol     (pol),
        .drv     (drv),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    generate
        if (GAP_BITS > 0) begin : g_gap
            assign rd_data = {pol == POL_HIGH, drv == DRV_PUSH, {GAP_BITS{1'b0}}, width};
        end else begin : g_nogap
            assign rd_data = {pol == POL_HIGH, drv == DRV_PUSH, width};
        end
    endgenerate

endmodule

// File: rtl/rstw_pulse_chk.sv
module rstw_pulse_chk
    import rstw_pkg::*;
#(
    parameter bit WIDE_PW = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        expire,
    input logic        ext_en,
    input logic        pulse_on,
    input logic        pad_out,
    input logic        pad_oe
);

    localparam int          PW   = field_bits(WIDE_PW);
    localparam logic [31:0] ZMSK = ~(32'hC000_0000 | ((32'd1 << PW) - 32'd1));

    logic key_hit;
    assign key_hit = (wr_data[31:24] == KEY_ACT_HIGH) || (wr_data[31:24] == KEY_ACT_LOW) ||
                     (wr_data[31:24] == KEY_PUSH)     || (wr_data[31:24] == KEY_OPEN);

    assert_zero_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ZMSK) == 32'd0);

    assert_key_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[31:24] == KEY_ACT_HIGH) |=> rd_data[RD_POL_BIT]);

    assert_key_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[31:24] == KEY_ACT_LOW) |=> !rd_data[RD_POL_BIT]);

    assert_key_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[31:24] == KEY_PUSH) |=> rd_data[RD_DRV_BIT]);

    assert_key_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[31:24] == KEY_OPEN) |=> !rd_data[RD_DRV_BIT]);

    assert_no_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !key_hit) |=> $stable(rd_data[31:30]));

    assert_width_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[PW-1:0] == $past(wr_data[PW-1:0]));

    assert_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_on && !(expire && ext_en)) |=> !pulse_on);

    assert_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ext_en) |=> pulse_on);

    assert_push_oe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[RD_DRV_BIT] |-> pad_oe);

    assert_open_oe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[RD_DRV_BIT] |-> (pad_oe == pulse_on));

    assert_open_lvl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[RD_DRV_BIT] && pad_oe) |-> (pad_out == rd_data[RD_POL_BIT]));

endmodule

bind rstw_pulse_gen rstw_pulse_chk #(.WIDE_PW(WIDE_PW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .expire   (expire),
    .ext_en   (ext_en),
    .pulse_on (pulse_on),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
);

// File: tb/rstw_pulse_gen_test.sv
module rstw_pulse_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        expire = 1'b0;
    logic        tick_us = 1'b0;
    logic        ext_en = 1'b0;
    logic        pad_out;
    logic        pad_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rstw_pulse_gen uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .expire  (expire),
        .tick_us (tick_us),
        .ext_en  (ext_en),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    typedef struct packed {
        logic [31:0] wd;
        logic [31:0] exp;
    } vec_t;

    // register write vectors: R3 R4 R5 R6 R2
    localparam vec_t VEC [8] = '{
        '{32'hA500_0003, 32'h8000_0003},
        '{32'hA800_0010, 32'hC000_0010},
        '{32'h5A00_00FF, 32'h4000_00FF},
        '{32'h8A01_2345, 32'h0001_2345},
        '{32'h12AB_CDEF, 32'h000B_CDEF},
        '{32'hA5FF_FFFF, 32'h800F_FFFF},
        '{32'h0000_0000, 32'h8000_0000},
        '{32'hA800_0001, 32'hC000_0001}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [31:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic fire();
        expire = 1'b1;
        @(negedge clk);
        expire = 1'b0;
    endtask

    task automatic one_tick();
        tick_us = 1'b1;
        @(negedge clk);
        tick_us = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_ticks(input logic lvl, output int n);
        n = 0;
        for (int g = 0; g < 300; g++) begin
            if (!(pad_oe && pad_out == lvl)) break;
            one_tick();
            n++;
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(rd_data == 32'h0000_00FF, "R1", rd_data, 32'h0000_00FF);
        check(pad_oe == 1'b0, "R1", {31'd0, pad_oe}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 8; i++) begin
            write_reg(VEC[i].wd);
            check(rd_data == VEC[i].exp, "R5_R3_R4_R6", rd_data, VEC[i].exp);
        end

        // open-drain, active high, width 3
        write_reg(32'hA500_0003);
        write_reg(32'h8A00_0003);
        ext_en = 1'b1;
        fire();
        // R11
        check(pad_oe && pad_out, "R11", {30'd0, pad_oe, pad_out}, 32'd3);
        pulse_ticks(1'b1, n);
        check(n == 4, "R7", n, 4);
        check(pad_oe == 1'b0, "R10", {31'd0, pad_oe}, 32'd0);

        // R7 width zero
        write_reg(32'h0000_0000);
        fire();
        pulse_ticks(1'b1, n);
        check(n == 1, "R7", n, 1);

        // R9 retrigger
        write_reg(32'h0000_0003);
        fire();
        one_tick();
        one_tick();
        fire();
        pulse_ticks(1'b1, n);
        check(n == 4, "R9", n, 4);

        // R8 ignored when disabled
        ext_en = 1'b0;
        fire();
        check(pad_oe == 1'b0, "R8", {31'd0, pad_oe}, 32'd0);
        one_tick();
        check(pad_oe == 1'b0, "R8", {31'd0, pad_oe}, 32'd0);

        // R10 push-pull, active high
        ext_en = 1'b1;
        write_reg(32'hA800_0002);
        check(pad_oe && !pad_out, "R10", {30'd0, pad_oe, pad_out}, 32'd2);
        fire();
        check(pad_oe && pad_out, "R10", {30'd0, pad_oe, pad_out}, 32'd3);
        pulse_ticks(1'b1, n);
        check(n == 3, "R7", n, 3);
        check(pad_oe && !pad_out, "R10", {30'd0, pad_oe, pad_out}, 32'd2);

        // R10 push-pull, active low
        write_reg(32'h5A00_0001);
        check(pad_oe && pad_out, "R10", {30'd0, pad_oe, pad_out}, 32'd3);
        fire();
        pulse_ticks(1'b0, n);
        check(n == 2, "R7", n, 2);

        // R10 open-drain, active low
        write_reg(32'h8A00_0001);
        check(!pad_oe, "R10", {31'd0, pad_oe}, 32'd0);
        fire();
        check(pad_oe && !pad_out, "R10", {30'd0, pad_oe, pad_out}, 32'd2);
        pulse_ticks(1'b0, n);
        check(n == 2, "R7", n, 2);

        // R2 read layout
        check(rd_data == 32'h0000_0001, "R2", rd_data, 32'h0000_0001);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

endmodule